// File: doc/BRIEF.md
# Two-Shot Supply Dip Sequencer

This block drives the 8-bit code of a digital-to-analogue converter that feeds a chip's supply rail. It makes one or two short negative supply dips at set times after a trigger. At rest the code is a programmable nominal value, and the rail voltage is code/255 of full scale. A rising edge on the asynchronous trigger input starts a sequence. The block waits a first delay, then holds a programmable low code for a first duration. If a second dip is enabled, it then waits a second delay and holds the same low code for a second duration. The second delay is counted from the end of the first dip, not from the trigger.

All delays and durations are 16-bit counts of system clock cycles. On the intended 100 MHz clock a count of one gives a 10 ns dip. The timing and code settings, apart from the nominal code, are captured when a sequence starts. Software can therefore prepare the next run while the current one plays out. The output code comes from a register, so it changes only at clock edges.

Top module: `dip_sequencer`

## Requirements
- R1: While reset is asserted, `code_o` is 255 and `busy_o` is 0. After reset, while the block is idle, `code_o` follows `nom_code_i` with one clock cycle of delay.
- R2: The trigger passes through a two-stage synchroniser. Take the first rising clock edge at which `trig_i` is high as edge 1. `busy_o` rises at edge 3, and the low code first appears at edge `off1_i`+3. An `off1_i` of 0 puts the low code at edge 3.
- R3: The first dip holds the captured low code for exactly `wid1_i` cycles. Every other cycle of the sequence shows the nominal code.
- R4: With `dbl_en_i` = 1, the second dip starts exactly `off2_i` cycles after the last cycle of the first dip. It holds the same low code for `wid2_i` cycles.
- R5: A width of zero removes that dip. With `wid1_i` = 0, the second dip starts `off1_i`+`off2_i` cycles after the start. With `dbl_en_i` = 0 or `wid2_i` = 0, the sequence ends with the first dip and `off2_i` adds no time. If every phase has zero length, a trigger does not raise `busy_o`.
- R6: `busy_o` is 1 for exactly the cycles of the sequence, which is the sum of the counted phases. `code_o` shows the nominal code again in the first cycle after `busy_o` falls.
- R7: A trigger edge is ignored if its synchronised edge lands while `busy_o` is 1, including the final busy cycle. The first accepted edge lands one cycle after `busy_o` falls.
- R8: Only a 0-to-1 change of the trigger starts a sequence. A trigger held high starts one sequence only.
- R9: Changing `low_code_i`, the offsets, the widths or `dbl_en_i` during a sequence has no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Asynchronous start trigger |
| nom_code_i | input | 8 | Code output at rest |
| low_code_i | input | 8 | Code output during either dip |
| off1_i | input | 16 | Cycles from trigger to first dip |
| wid1_i | input | 16 | First dip length in cycles |
| off2_i | input | 16 | Cycles from end of first dip to second dip |
| wid2_i | input | 16 | Second dip length in cycles |
| dbl_en_i | input | 1 | Enables the second dip |
| code_o | output | 8 | Registered converter code |
| busy_o | output | 1 | High while a sequence runs |

## Verification
The sensitive case is a new synchronised trigger edge arriving in the same cycle as the final phase of a running sequence expires. The bench provokes it by raising the trigger for a second time at a chosen offset from the first. It places that second edge exactly on the cycle in which the sequence ends, and must see no second sequence. It then moves the edge one cycle later, and must see a second full sequence begin the cycle after `busy_o` fell. Both runs are judged cycle by cycle against a model that computes every window from the settings.

// File: rtl/dip_seq_pkg.sv
package dip_seq_pkg;

    localparam int NUM_PH = 4;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_WAIT1 = 3'd1,
        PH_LOW1  = 3'd2,
        PH_WAIT2 = 3'd3,
        PH_LOW2  = 3'd4
    } phase_e;

endpackage

// File: rtl/dip_trig_sync.sv
module dip_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic trig_i,
    output logic rise_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[DEPTH-2:0], trig_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '0;
        else       sync_q <= sync_d;
    end

    assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];

endmodule

// File: rtl/dip_phase_pick.sv
module dip_phase_pick
    import dip_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  phase_e                        from_i,
    input  logic [NUM_PH-1:0][CNT_W-1:0]  lens_i,
    output phase_e                        next_o,
    output logic [CNT_W-1:0]              len_o
);
    always_comb begin
        logic found;
        found  = 1'b0;
        next_o = PH_IDLE;
        len_o  = '0;
        for (int k = 0; k < NUM_PH; k++) begin
            if (!found && (k + 1) > int'(from_i) && lens_i[k] != '0) begin
                found  = 1'b1;
                next_o = phase_e'(3'(k + 1));
                len_o  = lens_i[k];
            end
        end
    end

endmodule

// File: rtl/dip_seq_core.sv
module dip_seq_core
    import dip_seq_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          rise_i,
    input  logic [CODE_W-1:0]             nom_code_i,
    input  logic [CODE_W-1:0]             low_code_i,
    input  logic [NUM_PH-1:0][CNT_W-1:0]  live_lens_i,
    output logic [CODE_W-1:0]             code_o,
    output logic                          busy_o
);
    typedef struct packed {
        phase_e                        phase;
        logic [CNT_W-1:0]              cnt;
        logic [NUM_PH-1:0][CNT_W-1:0]  lens;
        logic [CODE_W-1:0]             low;
        logic [CODE_W-1:0]             code;
    } core_st_t;

    core_st_t st_d, st_q;

    logic                          idle;
    phase_e                        pick_next;
    logic [CNT_W-1:0]              pick_len;
    logic [NUM_PH-1:0][CNT_W-1:0]  pick_lens;

    assign idle      = (st_q.phase == PH_IDLE);
    assign pick_lens = idle ? live_lens_i : st_q.lens;

    dip_phase_pick #(.CNT_W(CNT_W)) u_pick (
        .from_i (st_q.phase),
        .lens_i (pick_lens),
        .next_o (pick_next),
        .len_o  (pick_len)
    );

    always_comb begin
        logic advance;
        st_d    = st_q;
        advance = 1'b0;
        if (idle) begin
            if (rise_i) begin
                st_d.lens = live_lens_i;
                st_d.low  = low_code_i;
                advance   = 1'b1;
            end
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            advance = 1'b1;
        end
        if (advance) begin
            st_d.phase = pick_next;
            st_d.cnt   = (pick_next == PH_IDLE) ? '0 : pick_len - 1'b1;
        end
        if (st_d.phase == PH_LOW1 || st_d.phase == PH_LOW2) st_d.code = st_d.low;
        else                                                 st_d.code = nom_code_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
            st_q.lens  <= '0;
            st_q.low   <= '0;
            st_q.code  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign busy_o = !idle;

endmodule

// File: rtl/dip_sequencer.sv
module dip_sequencer
    import dip_seq_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              trig_i,
    input  logic [CODE_W-1:0] nom_code_i,
    input  logic [CODE_W-1:0] low_code_i,
    input  logic [CNT_W-1:0]  off1_i,
    input  logic [CNT_W-1:0]  wid1_i,
    input  logic [CNT_W-1:0]  off2_i,
    input  logic [CNT_W-1:0]  wid2_i,
    input  logic              dbl_en_i,
    output logic [CODE_W-1:0] code_o,
    output logic              busy_o
);
    logic                          trig_rise;
    logic [NUM_PH-1:0][CNT_W-1:0]  live_lens;
    logic                          second_on;

    assign second_on    = dbl_en_i && (wid2_i != '0);
    assign live_lens[0] = off1_i;
    assign live_lens[1] = wid1_i;
    assign live_lens[2] = second_on ? off2_i : '0;
    assign live_lens[3] = second_on ? wid2_i : '0;

    dip_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .trig_i (trig_i),
        .rise_o (trig_rise)
    );

    dip_seq_core #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_core (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .rise_i      (trig_rise),
        .nom_code_i  (nom_code_i),
        .low_code_i  (low_code_i),
        .live_lens_i (live_lens),
        .code_o      (code_o),
        .busy_o      (busy_o)
    );

endmodule

// File: rtl/dip_sequencer_chk.sv
module dip_sequencer_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [CODE_W-1:0] nom_code_i,
    input logic [CODE_W-1:0] code_o,
    input logic              busy_o,
    input logic              trig_rise
);
    logic armed_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) armed_q <= 1'b0;
        else       armed_q <= 1'b1;
    end

    // R1: reset forces full-scale code and no activity
    a_r1_reset_state: assert property (@(posedge clk_i)
        rst_i |=> (code_o == '1 && !busy_o));

    // R6: whenever idle, the code is the nominal value of the previous cycle
    a_r6_idle_nominal: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && !busy_o) |-> code_o == $past(nom_code_i));

    // R7: a sequence starts only from a synchronised edge seen while idle
    a_r7_start_from_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(busy_o) |-> ($past(trig_rise) && !$past(busy_o)));

    // R8: the synchronised edge is a single-cycle pulse
    a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        trig_rise |=> !trig_rise);

endmodule

bind dip_sequencer dip_sequencer_chk #(.CODE_W(CODE_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .nom_code_i (nom_code_i),
    .code_o     (code_o),
    .busy_o     (busy_o),
    .trig_rise  (trig_rise)
);

// File: tb/dip_sequencer_bench.sv
module dip_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic [7:0]  nom = 8'hC0;
    logic [7:0]  low = 8'h40;
    logic [15:0] off1 = '0, wid1 = '0, off2 = '0, wid2 = '0;
    logic        dbl = 1'b0;
    logic [7:0]  code;
    logic        busy;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dip_sequencer u_dip_sequencer (
        .clk_i      (clk),
        .rst_i      (rst),
        .trig_i     (trig),
        .nom_code_i (nom),
        .low_code_i (low),
        .off1_i     (off1),
        .wid1_i     (wid1),
        .off2_i     (off2),
        .wid2_i     (wid2),
        .dbl_en_i   (dbl),
        .code_o     (code),
        .busy_o     (busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // expected busy/low for offset d into a sequence with the given settings
    function automatic void model(input int d, input int o1, input int w1, input int o2,
                                  input int w2, input bit en, output bit b, output bit l);
        int l3, l4, a2, b1, t;
        l3 = (en && w2 != 0) ? o2 : 0;
        l4 = (en && w2 != 0) ? w2 : 0;
        b1 = o1 + w1;
        a2 = b1 + l3;
        t  = a2 + l4;
        b  = (d >= 0 && d < t);
        l  = (d >= o1 && d < b1) || (d >= a2 && d < t);
    endfunction

    // First trigger raised before edge index 0; optional second raise after sample r2.
    task automatic run(input string req, input int o1, input int w1, input int o2,
                       input int w2, input bit en, input int r2, input bit hold,
                       input int chg_at, input int ncyc);
        int t, s2, bad_code, bad_busy, first_i;
        int act_c, exp_c, act_b, exp_b;
        bit b, l, b2, l2;
        logic [7:0] low_orig;
        low_orig = low;
        off1 = 16'(o1); wid1 = 16'(w1); off2 = 16'(o2); wid2 = 16'(w2); dbl = en;
        t = o1 + w1 + ((en && w2 != 0) ? (o2 + w2) : 0);
        s2 = (r2 >= 0 && r2 + 3 >= 2 + t + 1) ? r2 + 3 : -1;
        bad_code = 0; bad_busy = 0; first_i = -1;
        act_c = 0; exp_c = 0; act_b = 0; exp_b = 0;
        trig = 1'b1;
        for (int i = 0; i < ncyc; i++) begin
            @(posedge clk);
            @(negedge clk);
            model(i - 2, o1, w1, o2, w2, en, b, l);
            b2 = 1'b0; l2 = 1'b0;
            if (s2 >= 0) model(i - s2, o1, w1, o2, w2, en, b2, l2);
            if (int'(code) != int'((l || l2) ? low_orig : nom)) begin
                if (bad_code == 0) begin
                    act_c = int'(code); exp_c = int'((l || l2) ? low_orig : nom); first_i = i;
                end
                bad_code++;
            end
            if (busy != (b || b2)) begin
                if (bad_busy == 0) begin act_b = int'(busy); exp_b = int'(b || b2); end
                bad_busy++;
            end
            trig = hold || (i < 2) || (r2 >= 0 && i >= r2 && i < r2 + 3);
            if (i == chg_at) begin
                low = 8'h11; off1 = 16'd1; wid1 = 16'd9; off2 = 16'd1; wid2 = 16'd9; dbl = ~en;
            end
        end
        trig = 1'b0;
        low = low_orig;
        if (bad_code != 0) $display("  %s code mismatch first at cycle %0d", req, first_i);
        check({req, " code"}, act_c, exp_c);
        check({req, " busy"}, act_b, exp_b);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 reset code", int'(code), 255);
        check("R1 reset busy", int'(busy), 0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 idle nominal", int'(code), int'(nom));
        nom = 8'hB7;
        @(posedge clk); @(negedge clk);
        check("R1 idle follows nominal", int'(code), 8'hB7);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        // R2 R3: single dip
        run("R2_R3 single", 5, 3, 0, 0, 1'b0, -1, 1'b0, -1, 20);
        // R4: two dips, second offset from end of first
        run("R4 double", 4, 2, 3, 5, 1'b1, -1, 1'b0, -1, 24);
        // R2: zero offset, one-cycle widths back to back
        run("R2 zero offset", 0, 1, 0, 1, 1'b1, -1, 1'b0, -1, 10);
        // R5: first dip suppressed
        run("R5 no first dip", 3, 0, 2, 3, 1'b1, -1, 1'b0, -1, 16);
        // R5: second width zero, off2 adds nothing
        run("R5 no second width", 2, 4, 7, 0, 1'b1, -1, 1'b0, -1, 20);
        // R5: second disabled
        run("R5 second disabled", 2, 2, 5, 5, 1'b0, -1, 1'b0, -1, 20);
        // R5: everything zero, no busy
        run("R5 all zero", 0, 0, 0, 0, 1'b1, -1, 1'b0, -1, 10);
        // R7: retrigger in the middle ignored (t=14)
        run("R7 mid retrigger", 4, 2, 3, 5, 1'b1, 6, 1'b0, -1, 40);
        // R7: edge lands on the ending cycle, ignored
        run("R7 end collision", 4, 2, 3, 5, 1'b1, 13, 1'b0, -1, 40);
        // R7 R6: edge one cycle later, accepted
        run("R7_R6 first accepted", 4, 2, 3, 5, 1'b1, 14, 1'b0, -1, 40);
        // R8: trigger held high, single sequence
        run("R8 held trigger", 3, 2, 2, 2, 1'b1, -1, 1'b1, -1, 30);
        // R9: settings changed mid-sequence have no effect
        run("R9 settings captured", 6, 3, 2, 4, 1'b1, -1, 1'b0, 3, 30);
        summary();
        $finish;
    end

endmodule